// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block sits next to the pads of a 32-bit shared address/data bus that also carries a 4-bit command/byte-enable field. It covers both ends of the parity protocol. When this agent drives the bus, the block produces the even parity bit for each cycle's 36 bits and presents it one clock later. It also enables the parity driver one clock after the address/data drivers are enabled, and releases it one clock after they are released. When this agent receives, the block watches the frame, initiator-ready and target-ready strobes to find address phases and completed data transfers. It latches the parity of the bits at that edge and compares it with the parity line one clock later.

A data parity mismatch drives the active-low error line low for one clock. The line is then driven high for one clock before it is released. A mismatch in an address phase does not touch the error line. It pulses a separate address-error status bit instead.

Two small state machines do the sequencing. The phase tracker has the states PH_IDLE and PH_BUSY. It moves PH_IDLE→PH_BUSY when frame goes low, and PH_BUSY→PH_IDLE when frame and initiator-ready are both high. The error driver has the states PE_OFF, PE_LOW and PE_HIGH. It moves PE_OFF→PE_LOW on a data error, PE_LOW→PE_LOW on a further data error, and PE_LOW→PE_HIGH when there is none. From PE_HIGH it goes to PE_LOW on a data error and to PE_OFF otherwise.

Top module: `busparity_unit`

## Requirements
- R1: `par_out` in the cycle after any clock edge equals the XOR of the `ad_bus` and `cbe_bus` bits sampled at that edge, so the 37 bits have an even count of ones.
- R2: `par_oe` in the cycle after an edge equals `own_drive` sampled at that edge. The parity line is therefore enabled and released one cycle after the address/data lines, and it stays driven while `own_drive` is held high during idle.
- R3: The address phase is the first cycle with `frame_n` low while the tracker is in PH_IDLE. If this agent is not driving in that cycle (`own_drive`=0) and `par_in` in the next cycle differs from that cycle's parity, `addr_err` is 1 for exactly the cycle after the compare edge. `perr_oe` is not affected.
- R4: A data transfer is a non-address cycle with `irdy_n`=0 and `trdy_n`=0. If a transfer happens while `rx_active`=1 and `par_in` in the next cycle mismatches, `perr_oe`=1 and `perr_n`=0 for the cycle after that compare edge.
- R5: After a low cycle with no new error, `perr_n`=1 with `perr_oe`=1 for one cycle, and then `perr_oe`=0.
- R6: No error is raised when parity matches, when `rx_active`=0, or in a wait-state cycle where `irdy_n` or `trdy_n` is high.
- R7: While `rst`=1 at a clock edge, the following cycle has `par_oe`=0, `par_out`=0, `perr_oe`=0, `perr_n`=1 and `addr_err`=0, and no check is pending.
- R8: Back-to-back bad transfers keep `perr_n` low in each following cycle. An error that arrives during the high-drive cycle pulls the line low again.
- R9: An address phase driven by this agent (`own_drive`=1) is never checked.
- R10: The tracker returns to PH_IDLE only in a cycle where `frame_n` and `irdy_n` are both high. A `frame_n` low cycle inside a transaction is not an address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| own_drive | input | 1 | This agent drives address/data and command lines this cycle |
| ad_bus | input | 32 | Address/data value on the bus |
| cbe_bus | input | 4 | Command/byte-enable value on the bus |
| frame_n | input | 1 | Frame strobe, active low |
| irdy_n | input | 1 | Initiator-ready strobe, active low |
| trdy_n | input | 1 | Target-ready strobe, active low |
| rx_active | input | 1 | This agent receives the data of the current transaction |
| par_in | input | 1 | Parity line as seen on the bus |
| par_out | output | 1 | Generated parity bit |
| par_oe | output | 1 | Output enable for the parity driver |
| perr_n | output | 1 | Data parity error, active low |
| perr_oe | output | 1 | Output enable for the error driver |
| addr_err | output | 1 | One-cycle address parity error pulse |

## Verification
Suppose the phase tracker sits in the wrong state. Then an address phase is either missed or invented, and `addr_err` or `perr_n` shows it two edges after the affected cycle. A stale parity capture shows the same way, at the compare edge plus one. A wrong error-driver state shows as a missing or extra high-drive cycle on `perr_n`/`perr_oe` in the very next cycle. A bad generator pipeline shows on `par_out` or `par_oe` one cycle after the input changes. The bench runs a reference model of these rules against random strobe, data and corrupt-parity traffic. It also runs directed bursts that aim at error back-to-back, wait states and this agent's own address phases.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_state_t;

    typedef enum logic [1:0] {
        PE_OFF  = 2'd0,
        PE_LOW  = 2'd1,
        PE_HIGH = 2'd2
    } perr_state_t;
endpackage

// File: rtl/bpc_gen.sv
module bpc_gen #(
    parameter int BITS_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BITS_W-1:0] bits,
    input  logic              drive,
    output logic              par_out,
    output logic              par_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= ^bits;
            par_oe  <= drive;
        end
    end
endmodule

// File: rtl/bpc_phase.sv
module bpc_phase
    import bpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic trdy_n,
    output logic addr_phase,
    output logic data_xfer
);
    phase_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PH_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: state_d = frame_n ? PH_IDLE : PH_BUSY;
            PH_BUSY: state_d = (frame_n && irdy_n) ? PH_IDLE : PH_BUSY;
            default: state_d = PH_IDLE;
        endcase
    end

    always_comb begin
        addr_phase = (state_q == PH_IDLE) && !frame_n;
        data_xfer  = !addr_phase && !irdy_n && !trdy_n;
    end
endmodule

// File: rtl/bpc_check.sv
module bpc_check #(
    parameter int BITS_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BITS_W-1:0] bits,
    input  logic              cap_addr,
    input  logic              cap_data,
    input  logic              par_in,
    output logic              data_err,
    output logic              addr_err
);
    logic exp_q;
    logic pend_a_q;
    logic pend_d_q;
    logic mism;

    assign mism     = exp_q ^ par_in;
    assign data_err = pend_d_q && mism;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q    <= 1'b0;
            pend_a_q <= 1'b0;
            pend_d_q <= 1'b0;
            addr_err <= 1'b0;
        end else begin
            exp_q    <= ^bits;
            pend_a_q <= cap_addr;
            pend_d_q <= cap_data;
            addr_err <= pend_a_q && mism;
        end
    end
endmodule

// File: rtl/bpc_perr.sv
module bpc_perr
    import bpc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic data_err,
    output logic perr_n,
    output logic perr_oe
);
    perr_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= PE_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PE_OFF:  state_d = data_err ? PE_LOW : PE_OFF;
            PE_LOW:  state_d = data_err ? PE_LOW : PE_HIGH;
            PE_HIGH: state_d = data_err ? PE_LOW : PE_OFF;
            default: state_d = PE_OFF;
        endcase
    end

    always_comb begin
        perr_oe = (state_q != PE_OFF);
        perr_n  = (state_q != PE_LOW);
    end

    // R5: a low cycle without a new error is followed by one high-drive cycle
    assert_high_before_release_R5: assert property (@(posedge clk) disable iff (rst)
        (perr_oe && !perr_n && !data_err) |=> (perr_oe && perr_n));

    // R5: the high-drive cycle without a new error ends in release
    assert_release_after_high_R5: assert property (@(posedge clk) disable iff (rst)
        (perr_oe && perr_n && !data_err) |=> !perr_oe);
endmodule

// File: rtl/busparity_unit.sv
module busparity_unit #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             own_drive,
    input  logic [AD_W-1:0]  ad_bus,
    input  logic [CBE_W-1:0] cbe_bus,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             rx_active,
    input  logic             par_in,
    output logic             par_out,
    output logic             par_oe,
    output logic             perr_n,
    output logic             perr_oe,
    output logic             addr_err
);
    localparam int BITS_W = AD_W + CBE_W;

    logic [BITS_W-1:0] bits;
    logic addr_phase, data_xfer;
    logic cap_addr, cap_data;
    logic data_err;

    assign bits     = {cbe_bus, ad_bus};
    assign cap_addr = addr_phase && !own_drive;
    assign cap_data = data_xfer && rx_active;

    bpc_gen #(.BITS_W(BITS_W)) u_gen (
        .clk(clk), .rst(rst), .bits(bits), .drive(own_drive),
        .par_out(par_out), .par_oe(par_oe)
    );

    bpc_phase u_phase (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
        .addr_phase(addr_phase), .data_xfer(data_xfer)
    );

    bpc_check #(.BITS_W(BITS_W)) u_check (
        .clk(clk), .rst(rst), .bits(bits), .cap_addr(cap_addr), .cap_data(cap_data),
        .par_in(par_in), .data_err(data_err), .addr_err(addr_err)
    );

    bpc_perr u_perr (
        .clk(clk), .rst(rst), .data_err(data_err),
        .perr_n(perr_n), .perr_oe(perr_oe)
    );

    // R2: parity driver is released one cycle after the address/data drivers
    assert_par_release_lag_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(par_oe) |-> (!$past(own_drive) && $past(own_drive, 2)));

    // R4: a low error line always traces back to a received transfer two edges earlier
    assert_perr_has_cause_R4: assert property (@(posedge clk) disable iff (rst)
        (perr_oe && !perr_n) |-> $past(!irdy_n && !trdy_n && rx_active, 2));

    // R3: an address error never drives the data error line low
    assert_addr_err_separate_R3: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> !(perr_oe && !perr_n));

    // R9: an address error needs an address cycle not driven by this agent
    assert_no_own_addr_check_R9: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> ($past(!own_drive, 2) && $past(!frame_n, 2)));
endmodule

// File: tb/tb_busparity_unit.sv
`timescale 1ns/1ps
module tb_busparity_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        own_drive = 1'b0;
    logic [31:0] ad_bus = '0;
    logic [3:0]  cbe_bus = '0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic        rx_active = 1'b0;
    logic        par_in = 1'b0;
    logic        par_out, par_oe, perr_n, perr_oe, addr_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_idle = 1, m_pa = 0, m_pd = 0, m_exp = 0;
    int m_pst = 0; // 0 off, 1 low, 2 high
    bit m_aerr = 0, m_par = 0, m_paroe = 0;
    bit prev_par = 0;

    always #2.5 clk = ~clk;

    busparity_unit dut (
        .clk(clk), .rst(rst), .own_drive(own_drive), .ad_bus(ad_bus), .cbe_bus(cbe_bus),
        .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .rx_active(rx_active),
        .par_in(par_in), .par_out(par_out), .par_oe(par_oe), .perr_n(perr_n),
        .perr_oe(perr_oe), .addr_err(addr_err)
    );

    function automatic bit even_par(input logic [31:0] a, input logic [3:0] c);
        return ^{c, a};
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit mism, derr, aph;
        if (rst) begin
            m_idle = 1; m_pa = 0; m_pd = 0; m_exp = 0; m_pst = 0;
            m_aerr = 0; m_par = 0; m_paroe = 0;
        end else begin
            mism   = m_exp ^ par_in;
            derr   = m_pd & mism;
            m_aerr = m_pa & mism;
            case (m_pst)
                0: m_pst = derr ? 1 : 0;
                1: m_pst = derr ? 1 : 2;
                default: m_pst = derr ? 1 : 0;
            endcase
            aph     = m_idle & !frame_n;
            m_pa    = aph & !own_drive;
            m_pd    = !aph & !irdy_n & !trdy_n & rx_active;
            m_exp   = even_par(ad_bus, cbe_bus);
            m_idle  = m_idle ? frame_n : (frame_n & irdy_n);
            m_par   = even_par(ad_bus, cbe_bus);
            m_paroe = own_drive;
        end
    endtask

    // one bus cycle: inputs already applied; edge; compare at the falling edge
    task automatic cycle();
        @(posedge clk);
        model_edge();
        prev_par = even_par(ad_bus, cbe_bus);
        @(negedge clk);
        check(par_out,  m_par,         "R1 par_out");
        check(par_oe,   m_paroe,       "R2 par_oe");
        check(addr_err, m_aerr,        "R3 addr_err");
        check(perr_n,   m_pst != 1,    "R4 perr_n");
        check(perr_oe,  m_pst != 0,    "R5 perr_oe");
    endtask

    task automatic drive(input bit fr, input bit ir, input bit tr, input bit own,
                         input bit rx, input logic [31:0] a, input logic [3:0] c,
                         input bit flip);
        frame_n = fr; irdy_n = ir; trdy_n = tr; own_drive = own; rx_active = rx;
        ad_bus = a; cbe_bus = c; par_in = prev_par ^ flip;
        cycle();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        drive(1, 1, 1, 0, 0, 32'h0, 4'h0, 0);
        // R7: reset state
        check(par_oe,   0, "R7 par_oe after reset");
        check(par_out,  0, "R7 par_out after reset");
        check(perr_oe,  0, "R7 perr_oe after reset");
        check(perr_n,   1, "R7 perr_n after reset");
        check(addr_err, 0, "R7 addr_err after reset");
        rst = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();
        drive(1, 1, 1, 0, 0, 32'h0, 4'h0, 0);

        // R4/R5/R8: received write burst with two back-to-back bad transfers
        drive(0, 1, 1, 0, 1, 32'h1234_5678, 4'h7, 0);
        drive(0, 0, 0, 0, 1, 32'hDEAD_BEEF, 4'h0, 0);
        drive(0, 0, 0, 0, 1, 32'h0000_0001, 4'h0, 1);
        check(perr_n, 0, "R4 first bad transfer");
        drive(1, 0, 0, 0, 1, 32'hFFFF_0000, 4'h3, 1);
        check(perr_n, 0, "R8 consecutive bad transfer");
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 0);
        check(perr_n & perr_oe, 1, "R5 high drive cycle");
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 0);
        check(perr_oe, 0, "R5 released");

        // R8: error arriving during the high-drive cycle re-asserts
        drive(0, 1, 1, 0, 1, 32'h5, 4'h1, 0);
        drive(0, 0, 0, 0, 1, 32'h6, 4'h0, 0);
        drive(0, 1, 1, 0, 1, 32'h6, 4'h0, 1);
        check(perr_n, 0, "R8 first low");
        drive(0, 0, 0, 0, 1, 32'h7, 4'h0, 0);
        check(perr_n, 1, "R8 high cycle");
        drive(1, 0, 0, 0, 1, 32'h8, 4'h0, 1);
        check(perr_n, 0, "R8 re-assert from high");
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 0);
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 0);
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 0);

        // R6: bad parity with rx_active low and in a wait state
        drive(0, 1, 1, 1, 0, 32'hA5A5_A5A5, 4'hC, 0);
        drive(1, 0, 0, 1, 0, 32'h1, 4'h0, 1);
        drive(1, 1, 1, 0, 0, 32'h0, 4'h0, 1);
        check(perr_oe, 0, "R6 not receiving");
        drive(0, 1, 1, 0, 1, 32'h3, 4'h0, 0);
        drive(0, 0, 1, 0, 1, 32'h3, 4'h0, 0);
        drive(1, 0, 1, 0, 1, 32'h3, 4'h0, 1);
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 1);
        check(perr_oe, 0, "R6 wait state ignored");

        // R9: own address phase with bad parity is not checked
        drive(0, 1, 1, 1, 0, 32'hF0F0_0000, 4'h6, 0);
        drive(1, 1, 1, 0, 0, 32'h0, 4'h0, 1);
        drive(1, 1, 1, 0, 0, 32'h0, 4'h0, 0);
        check(addr_err, 0, "R9 own address unchecked");

        // R3: foreign address phase with bad parity pulses addr_err only
        drive(0, 1, 1, 0, 1, 32'h0F0F_0000, 4'h6, 0);
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 1);
        check(addr_err, 1, "R3 address error pulse");
        check(perr_oe, 0, "R3 perr untouched");
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 0);
        check(addr_err, 0, "R3 pulse one cycle");

        // R10: frame low mid-transaction is not an address phase
        drive(0, 1, 1, 1, 0, 32'h10, 4'h6, 0);
        drive(1, 0, 1, 0, 0, 32'h11, 4'h0, 0);
        drive(0, 1, 1, 0, 1, 32'h12, 4'h0, 0);
        drive(1, 1, 1, 0, 1, 32'h0, 4'h0, 1);
        check(addr_err, 0, "R10 no address phase while busy");
        drive(1, 1, 1, 0, 0, 32'h0, 4'h0, 0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            bit fr, ir, tr, own, rx, fl;
            if ($urandom_range(0, 199) == 0) begin
                do_reset();
                continue;
            end
            fr  = ($urandom_range(0, 2) != 0);
            ir  = ($urandom_range(0, 2) == 0);
            tr  = ($urandom_range(0, 2) == 0);
            own = $urandom_range(0, 1);
            rx  = $urandom_range(0, 1);
            fl  = ($urandom_range(0, 4) == 0);
            drive(fr, ir, tr, own, rx, $urandom, 4'($urandom), fl);
        end

        // R1: parity generator directed corners
        drive(1, 1, 1, 1, 0, 32'hFFFF_FFFF, 4'hF, 0);
        drive(1, 1, 1, 1, 0, 32'h0000_0001, 4'h0, 0);
        check(par_out, 1, "R1 single one gives parity 1");
        check(par_oe, 1, "R2 idle drive keeps parity enabled");
        drive(1, 1, 1, 0, 0, 32'h0, 4'h0, 0);
        check(par_oe, 0, "R2 release one cycle later");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule